// File: doc/BRIEF.md
# Rotating Word Display

This block drives a row of seven-segment displays with a three-character word. Each character is a 2-bit code, so the word can use the letters d and E, one digit and a blank glyph. A position select moves the word one display to the left for each step up in value. The displays that do not hold a word character show blank. When the word reaches the left edge of the row it splits, and its leading characters come back in on the rightmost displays. The block is purely combinational, so every output follows its inputs with no clock.

The row length is a parameter. It is normally 6 or 8, and a row of 3 is also allowed, in which case the word simply rotates. The select width is derived from the row length: 3 bits for 6 or 8 displays and 2 bits for 3. Each display has its own multiplexer over the select values. That multiplexer picks one of the word's characters, or blank, and a per-display decoder turns the chosen code into active-low segment drive. The glyph used for code 10 is set by a parameter and is either the digit 1 or the digit 2.

Top module: `rotating_word_display`

## Requirements
- R1: Code 00 shows d (segments b c d e g lit), 01 shows E (a d e f g lit) and 11 shows blank (nothing lit). Segments are active low, bit 0 of each 7-bit field is segment a and bit 6 is segment g, and display i occupies `seg_o[7*i +: 7]`, where display 0 is the rightmost.
- R2: Code 10 shows the digit chosen by parameter DIGIT: 1 lights b c, and 2 lights a b d e g.
- R3: At select 0 the word fills displays 2, 1 and 0, with `char0_i` on display 2, `char1_i` on display 1 and `char2_i` on display 0.
- R4: For select s from 0 to NUM_DISP-3, `char0_i` is on display s+2, `char1_i` on display s+1 and `char2_i` on display s.
- R5: At select NUM_DISP-2 and NUM_DISP-1 the word wraps around the row edge, and character k lands on display (s+2-k) mod NUM_DISP. With 6 displays, read left to right, select 100 gives E 1 . . . d and select 101 gives 1 . . . d E.
- R6: Every display not holding one of the three word characters shows blank, so exactly three displays carry the word.
- R7: A select value of NUM_DISP or more (110 and 111 with 6 displays) blanks every display.
- R8: With NUM_DISP = 3 the select is 2 bits wide. Values 00, 01 and 10 give the orders d E 1, E 1 d and 1 d E, read left to right, for the word d E 1, and 11 blanks every display.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| char0_i | input | 2 | First (leftmost) word character code |
| char1_i | input | 2 | Middle word character code |
| char2_i | input | 2 | Last (rightmost) word character code |
| sel_i | input | $clog2(NUM_DISP) | Word position select |
| seg_o | output | 7*NUM_DISP | Active-low segments, display 0 in the low 7 bits |

## Verification
A slot multiplexer wired to the wrong character index shows up at once, on the same input change: one display carries a wrong glyph, or the word appears in the wrong order for a single select value. This is most likely at the wrapped positions, where the index arithmetic is modulo the row length. A wrong blank or range decision shows up as a count of lit displays that is not three, or a glyph left on screen for an unused select value. A bad decoder entry is seen on every display that shows that code. The sweeps cover all 64 words at every select value for rows of 6 (digit 1), 8 (digit 2) and 3, so each of these faults reaches a port.

// File: rtl/word_disp_pkg.sv
package word_disp_pkg;

  typedef logic [1:0] glyph_code_t;
  typedef logic [6:0] seg_t;

  localparam glyph_code_t CODE_D     = 2'b00;
  localparam glyph_code_t CODE_E     = 2'b01;
  localparam glyph_code_t CODE_DIGIT = 2'b10;
  localparam glyph_code_t CODE_BLANK = 2'b11;

  // Active low, bit 0 = a ... bit 6 = g
  localparam seg_t SEG_D     = 7'b0100001;
  localparam seg_t SEG_E     = 7'b0000110;
  localparam seg_t SEG_ONE   = 7'b1111001;
  localparam seg_t SEG_TWO   = 7'b0100100;
  localparam seg_t SEG_BLANK = 7'b1111111;

  // Which word character a display carries for a given select value.
  // A result of word_len or more means the display is blank padding.
  function automatic int slot_char_index(input int sel, input int disp,
                                         input int ndisp, input int word_len);
    if (sel >= ndisp) return word_len;
    return (sel + ndisp + word_len - 1 - disp) % ndisp;
  endfunction

  function automatic seg_t glyph_of(input glyph_code_t code, input int digit);
    seg_t r;
    case (code)
      CODE_D:     r = SEG_D;
      CODE_E:     r = SEG_E;
      CODE_DIGIT: r = (digit == 2) ? SEG_TWO : SEG_ONE;
      default:    r = SEG_BLANK;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/glyph_decoder.sv
module glyph_decoder
  import word_disp_pkg::*;
#(
  parameter int DIGIT = 1
) (
  input  logic [1:0] code_i,
  output logic [6:0] seg_o
);

  always_comb seg_o = glyph_of(code_i, DIGIT);

  always_comb begin
    if (!$isunknown(code_i)) begin
      // R1
      blank_glyph_chk: assert ((code_i == CODE_BLANK) == (seg_o == SEG_BLANK))
        else $error("blank glyph mismatch for code %b", code_i);
      // R2
      glyph_lit_chk: assert (code_i == CODE_BLANK || $countones(~seg_o) >= 2)
        else $error("glyph for code %b lights too few segments", code_i);
    end
  end

endmodule

// File: rtl/slot_select.sv
module slot_select
  import word_disp_pkg::*;
#(
  parameter int NUM_DISP = 6,
  parameter int WORD_LEN = 3,
  parameter int DISP_IDX = 0,
  parameter int SEL_W    = 3
) (
  input  logic [2*WORD_LEN-1:0] word_i,
  input  logic [SEL_W-1:0]      sel_i,
  output logic [1:0]            code_o,
  output logic                  busy_o
);

  localparam int SEL_NUM = 1 << SEL_W;

  logic [1:0] cand_code [SEL_NUM];
  logic       cand_busy [SEL_NUM];

  for (genvar v = 0; v < SEL_NUM; v++) begin : g_cand
    localparam int K = slot_char_index(v, DISP_IDX, NUM_DISP, WORD_LEN);
    if (K < WORD_LEN) begin : g_word
      assign cand_code[v] = word_i[2*K +: 2];
      assign cand_busy[v] = 1'b1;
    end else begin : g_pad
      assign cand_code[v] = CODE_BLANK;
      assign cand_busy[v] = 1'b0;
    end
  end

  assign code_o = cand_code[sel_i];
  assign busy_o = cand_busy[sel_i];

  always_comb begin
    if (!$isunknown(sel_i)) begin
      // R7
      slot_range_chk: assert (!busy_o || int'(sel_i) < NUM_DISP)
        else $error("display %0d busy at select %0d", DISP_IDX, sel_i);
      // R6
      slot_pad_chk: assert (busy_o || code_o == CODE_BLANK)
        else $error("display %0d padding not blank", DISP_IDX);
    end
  end

endmodule

// File: rtl/rotating_word_display.sv
module rotating_word_display
  import word_disp_pkg::*;
#(
  parameter int NUM_DISP = 6,
  parameter int DIGIT    = 1
) (
  input  logic [1:0]                   char0_i,
  input  logic [1:0]                   char1_i,
  input  logic [1:0]                   char2_i,
  input  logic [$clog2(NUM_DISP)-1:0]  sel_i,
  output logic [7*NUM_DISP-1:0]        seg_o
);

  localparam int WORD_LEN = 3;
  localparam int SEL_W    = $clog2(NUM_DISP);

  logic [2*WORD_LEN-1:0] word;
  logic [1:0]            disp_code [NUM_DISP];
  logic [NUM_DISP-1:0]   disp_busy;

  assign word = {char2_i, char1_i, char0_i};

  for (genvar i = 0; i < NUM_DISP; i++) begin : g_disp
    slot_select #(
      .NUM_DISP(NUM_DISP),
      .WORD_LEN(WORD_LEN),
      .DISP_IDX(i),
      .SEL_W   (SEL_W)
    ) u_slot (
      .word_i(word),
      .sel_i (sel_i),
      .code_o(disp_code[i]),
      .busy_o(disp_busy[i])
    );

    glyph_decoder #(.DIGIT(DIGIT)) u_dec (
      .code_i(disp_code[i]),
      .seg_o (seg_o[7*i +: 7])
    );
  end

  always_comb begin
    if (!$isunknown(sel_i)) begin
      // R6
      word_count_chk: assert ($countones(disp_busy) ==
                              ((int'(sel_i) < NUM_DISP) ? WORD_LEN : 0))
        else $error("busy display count wrong at select %0d", sel_i);
    end
    if (!$isunknown({sel_i, char2_i})) begin
      // R3
      home_pos_chk: assert (sel_i != '0 || disp_code[0] == char2_i)
        else $error("rightmost display not holding last character");
    end
  end

endmodule

// File: tb/tb_rotating_word_display.sv
module tb_rotating_word_display;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [1:0] c0, c1, c2;
  logic [2:0] sel6, sel8;
  logic [1:0] sel3;
  logic [41:0] seg6;
  logic [55:0] seg8;
  logic [20:0] seg3;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  rotating_word_display #(.NUM_DISP(6), .DIGIT(1)) dut (
    .char0_i(c0), .char1_i(c1), .char2_i(c2), .sel_i(sel6), .seg_o(seg6));
  rotating_word_display #(.NUM_DISP(8), .DIGIT(2)) dut8 (
    .char0_i(c0), .char1_i(c1), .char2_i(c2), .sel_i(sel8), .seg_o(seg8));
  rotating_word_display #(.NUM_DISP(3), .DIGIT(1)) dut3 (
    .char0_i(c0), .char1_i(c1), .char2_i(c2), .sel_i(sel3), .seg_o(seg3));

  // Glyph built from the list of lit segment letters
  function automatic logic [6:0] exp_glyph(input logic [1:0] code, input int digit);
    string lit;
    logic [6:0] r = 7'h7f;
    case (code)
      2'b00: lit = "bcdeg";
      2'b01: lit = "adefg";
      2'b10: lit = (digit == 2) ? "abdeg" : "bc";
      default: lit = "";
    endcase
    for (int j = 0; j < lit.len(); j++) r[lit[j] - 8'h61] = 1'b0;
    return r;
  endfunction

  function automatic logic [55:0] exp_row(input int n, input int digit,
                                          input logic [1:0] a, input logic [1:0] b,
                                          input logic [1:0] c, input int s);
    logic [55:0] r = '1;
    logic [1:0] ch [3];
    ch[0] = a; ch[1] = b; ch[2] = c;
    if (s < n) begin
      for (int k = 0; k < 3; k++) begin
        int pos = s + 2 - k;
        if (pos >= n) pos -= n;
        r[pos*7 +: 7] = exp_glyph(ch[k], digit);
      end
    end
    return r;
  endfunction

  function automatic string tag_of(input int n, input int s);
    if (n == 3) return "R8";
    if (s >= n) return "R7";
    if (s == 0) return "R3";
    if (s > n - 3) return "R5";
    return "R4";
  endfunction

  task automatic check_row(input string tag, input int n, input logic [55:0] act,
                           input logic [55:0] exp);
    logic [55:0] mask = (56'd1 << (7*n)) - 56'd1;
    checks++;
    if ((act & mask) !== (exp & mask)) begin
      fails++;
      $display("FAIL %s n=%0d sel6=%0d word=%b%b%b act=%h exp=%h",
               tag, n, sel6, c0, c1, c2, act & mask, exp & mask);
    end
  endtask

  task automatic check_blanks(input int n, input logic [55:0] act, input int s);
    int nb = 0;
    int want = (s < n) ? n - 3 : n;
    for (int i = 0; i < n; i++) if (act[i*7 +: 7] == 7'h7f) nb++;
    // R6: padding count, only meaningful when no word code is blank
    if (c0 != 2'b11 && c1 != 2'b11 && c2 != 2'b11) begin
      checks++;
      if (nb != want) begin
        fails++;
        $display("FAIL R6 n=%0d sel=%0d blank displays act=%0d exp=%0d", n, s, nb, want);
      end
    end
  endtask

  initial begin
    c0 = 2'b00; c1 = 2'b00; c2 = 2'b00;
    sel6 = '0; sel8 = '0; sel3 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // R1 / R2: each code decoded on display 0 at select 0
    for (int code = 0; code < 4; code++) begin
      @(posedge clk);
      c2 = code[1:0]; sel6 = 3'd0; sel8 = 3'd0; sel3 = 2'd0;
      @(negedge clk);
      checks++;
      if (seg6[6:0] !== exp_glyph(code[1:0], 1)) begin
        fails++;
        $display("FAIL %s code=%0d act=%b exp=%b", (code == 2) ? "R2" : "R1",
                 code, seg6[6:0], exp_glyph(code[1:0], 1));
      end
      checks++;
      if (seg8[6:0] !== exp_glyph(code[1:0], 2)) begin
        fails++;
        $display("FAIL %s digit2 code=%0d act=%b exp=%b", (code == 2) ? "R2" : "R1",
                 code, seg8[6:0], exp_glyph(code[1:0], 2));
      end
    end

    // R3 R4 R5 R6 R7 R8: every word at every select value
    for (int s = 0; s < 8; s++) begin
      for (int w = 0; w < 64; w++) begin
        @(posedge clk);
        c0 = w[5:4]; c1 = w[3:2]; c2 = w[1:0];
        sel6 = s[2:0]; sel8 = s[2:0]; sel3 = s[1:0];
        @(negedge clk);
        check_row(tag_of(6, s), 6, {14'h3fff, seg6}, exp_row(6, 1, c0, c1, c2, s));
        check_row(tag_of(8, s), 8, seg8, exp_row(8, 2, c0, c1, c2, s));
        check_blanks(6, {14'h3fff, seg6}, s);
        check_blanks(8, seg8, s);
        if (s < 4)
          check_row(tag_of(3, s), 3, {35'h7ffffffff, seg3}, exp_row(3, 1, c0, c1, c2, s));
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule